// File: doc/BRIEF.md
# Paired Frame Sync Pulse Generator

This block derives two timing pulses from a recovered reference clock: a frame pulse and a multiframe pulse. The reference clock arrives as a one-cycle tick enable in the system clock domain. Several candidate inputs each offer a tick line and a sync level line. One register field picks the input whose ticks drive the counters. A second field picks the input whose rising edges anchor the phase. The pulses therefore follow the frequency of the chosen clock and take their phase from the chosen sync source.

A frame lasts `TICKS_PER_FRAME` reference ticks, which nominally gives 8 kHz. Four frames make one multiframe, which nominally gives 2 kHz. `FRAMES_PER_PPS` frames make one second. Each output can be switched from its nominal rate to a once-per-second pulse. A 2-bit field states the rate the sync source is expected to carry. That rate decides which counters a sync edge re-anchors, and it also sets the counter position at which an edge counts as on time. An edge that arrives off time sets a sticky status flag, and a clear strobe resets the flag. Until the first sync edge after reset, the counters run freely on the ticks.

Top module: `frame_sync_gen`

## Requirements
- R1: During and straight after reset, `frame_pulse_o`, `mframe_pulse_o` and `misalign_o` are 0 and all phase counters sit at position zero. The first selected tick then produces a frame pulse, a multiframe pulse and a second pulse.
- R2: With `cfg_frame_pps`=0, `frame_pulse_o` is high for the tick period that follows every tick at frame position zero. Without sync edges, this happens once every `TICKS_PER_FRAME` selected ticks.
- R3: With `cfg_mframe_pps`=0, `mframe_pulse_o` is high for the tick period that follows every fourth frame pulse.
- R4: With `cfg_frame_pps`=1 (or `cfg_mframe_pps`=1), the output in question pulses only on the first frame of each second, which is one frame in every `FRAMES_PER_PPS`.
- R5: Only `ref_tick_i[cfg_clk_sel]` advances the counters, and only `sync_i[cfg_sync_sel]` supplies edges. Ticks and sync activity on other inputs have no effect.
- R6: The `cfg_sync_rate` codes are 0 = 1 PPS, 1 = 2 kHz, 2 = 4 kHz and 3 = 8 kHz. Every sync edge zeroes the tick-in-frame position. Codes 0 and 1 also zero the multiframe count. Code 0 also zeroes the frame-in-second count.
- R7: A rising edge is a 0 in one cycle followed by a 1 in the next. If the edge falls in a cycle that also carries a selected tick, that tick emits the realigned pulses. Otherwise the next selected tick emits them.
- R8: An edge is on time when, before the edge is applied, the tick position is 0 and the following also holds: for code 0 the multiframe and second counts are 0; for code 1 the multiframe count is 0; for code 2 the multiframe count is even; code 3 adds nothing. An edge that is not on time sets `misalign_o` from the next cycle onward.
- R9: `misalign_o` stays set until a cycle with `status_clr`=1. If an off-time edge arrives in the same cycle as the clear, the flag stays set.
- R10: The outputs change only in the cycle after a selected tick, so each pulse lasts exactly one reference-tick period.
- R11: The first sync edge after reset is never flagged, whatever its position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | NUM_IN | Reference tick enables, one per input |
| sync_i | input | NUM_IN | Sync levels, one per input, already synchronous to `clk` |
| cfg_clk_sel | input | SEL_W | Index of the input whose ticks drive the counters |
| cfg_sync_sel | input | SEL_W | Index of the input whose edges set the phase |
| cfg_sync_rate | input | 2 | Expected sync rate code (see R6) |
| cfg_frame_pps | input | 1 | 1: frame output pulses once per second |
| cfg_mframe_pps | input | 1 | 1: multiframe output pulses once per second |
| status_clr | input | 1 | Clears the misalignment flag |
| frame_pulse_o | output | 1 | Frame sync pulse |
| mframe_pulse_o | output | 1 | Multiframe sync pulse |
| misalign_o | output | 1 | Sticky flag for an off-time sync edge |

## Verification
Two pairs of events can fall in the same cycle. The first is a sync edge arriving in the very cycle that carries a selected reference tick. The bench waits on its own model until the next cycle holds a tick and only then raises the sync line. It also waits for a cycle with no tick and repeats the edge there. A pulse must then appear on that tick or on the following tick. The second is an off-time edge arriving together with the clear strobe. That case is provoked in the same way, and the flag must stay set. Each cycle is compared against the bench's own counter model.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        RATE_PPS = 2'd0,
        RATE_2K  = 2'd1,
        RATE_4K  = 2'd2,
        RATE_8K  = 2'd3
    } sync_rate_e;

    typedef struct packed {
        logic frame;
        logic mframe;
        logic second;
    } fsg_evt_t;

    // a sync edge at this rate also restarts the multiframe count
    function automatic logic rate_clears_mf(sync_rate_e r);
        return (r == RATE_PPS) || (r == RATE_2K);
    endfunction

    // a sync edge at this rate also restarts the frame-in-second count
    function automatic logic rate_clears_sec(sync_rate_e r);
        return (r == RATE_PPS);
    endfunction

    // on-time test for the slower counters, given the rate
    function automatic logic slow_phase_ok(sync_rate_e r, logic [1:0] mf, logic sec_zero);
        logic ok;
        case (r)
            RATE_PPS: ok = (mf == 2'd0) && sec_zero;
            RATE_2K:  ok = (mf == 2'd0);
            RATE_4K:  ok = ~mf[0];
            default:  ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/fsg_src_sel.sv
module fsg_src_sel #(
    parameter int NUM_IN = 14,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] ref_tick_i,
    input  logic [NUM_IN-1:0] sync_i,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [SEL_W-1:0]  sync_sel,
    output logic              tick_o,
    output logic              edge_o
);
    logic sync_cur;
    logic sync_prev_q;

    always_comb begin
        tick_o   = 1'b0;
        sync_cur = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (clk_sel == SEL_W'(i))  tick_o   = ref_tick_i[i];
            if (sync_sel == SEL_W'(i)) sync_cur = sync_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_prev_q <= 1'b0;
        else     sync_prev_q <= sync_cur;
    end

    assign edge_o = sync_cur & ~sync_prev_q;

endmodule

// File: rtl/fsg_phase_ctr.sv
module fsg_phase_ctr
    import fsg_pkg::*;
#(
    parameter int TPF = 1250,
    parameter int FPS = 8000,
    localparam int TW = (TPF > 1) ? $clog2(TPF) : 1,
    localparam int FW = (FPS > 1) ? $clog2(FPS) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       edge_i,
    input  sync_rate_e rate_i,
    output fsg_evt_t   evt_o,
    output logic       aligned_o,
    output logic [TW-1:0] pos_o
);
    logic [TW-1:0] tick_q, tick_eff;
    logic [1:0]    mf_q, mf_eff;
    logic [FW-1:0] sec_q, sec_eff;
    logic          frame_end;

    always_comb begin
        tick_eff  = edge_i ? '0 : tick_q;
        mf_eff    = (edge_i && rate_clears_mf(rate_i))  ? 2'd0 : mf_q;
        sec_eff   = (edge_i && rate_clears_sec(rate_i)) ? '0   : sec_q;
        frame_end = (tick_eff == TW'(TPF - 1));

        evt_o.frame  = (tick_eff == '0);
        evt_o.mframe = evt_o.frame && (mf_eff == 2'd0);
        evt_o.second = evt_o.frame && (sec_eff == '0);

        aligned_o = (tick_q == '0) && slow_phase_ok(rate_i, mf_q, sec_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            mf_q   <= 2'd0;
            sec_q  <= '0;
        end else if (tick_i) begin
            if (frame_end) begin
                tick_q <= '0;
                mf_q   <= mf_eff + 2'd1;
                sec_q  <= (sec_eff == FW'(FPS - 1)) ? '0 : sec_eff + FW'(1);
            end else begin
                tick_q <= tick_eff + TW'(1);
                mf_q   <= mf_eff;
                sec_q  <= sec_eff;
            end
        end else begin
            tick_q <= tick_eff;
            mf_q   <= mf_eff;
            sec_q  <= sec_eff;
        end
    end

    assign pos_o = tick_q;

endmodule

// File: rtl/fsg_status.sv
module fsg_status (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic aligned_i,
    input  logic clr_i,
    output logic bad_o,
    output logic flag_o
);
    logic armed_q;
    logic flag_q;

    assign bad_o = edge_i & armed_q & ~aligned_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (edge_i) armed_q <= 1'b1;
            if (bad_o)      flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/fsg_pulse_out.sv
module fsg_pulse_out
    import fsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  fsg_evt_t evt_i,
    input  logic     frame_pps_i,
    input  logic     mframe_pps_i,
    output logic     frame_o,
    output logic     mframe_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_o  <= 1'b0;
            mframe_o <= 1'b0;
        end else if (tick_i) begin
            frame_o  <= frame_pps_i  ? evt_i.second : evt_i.frame;
            mframe_o <= mframe_pps_i ? evt_i.second : evt_i.mframe;
        end
    end

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int NUM_IN          = 14,
    parameter int TICKS_PER_FRAME = 1250,
    parameter int FRAMES_PER_PPS  = 8000,
    localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] ref_tick_i,
    input  logic [NUM_IN-1:0] sync_i,
    input  logic [SEL_W-1:0]  cfg_clk_sel,
    input  logic [SEL_W-1:0]  cfg_sync_sel,
    input  logic [1:0]        cfg_sync_rate,
    input  logic              cfg_frame_pps,
    input  logic              cfg_mframe_pps,
    input  logic              status_clr,
    output logic              frame_pulse_o,
    output logic              mframe_pulse_o,
    output logic              misalign_o
);
    localparam int POS_W = (TICKS_PER_FRAME > 1) ? $clog2(TICKS_PER_FRAME) : 1;

    logic             tick_sel;
    logic             sync_edge;
    logic             seg_aligned;
    logic             edge_bad;
    logic [POS_W-1:0] tick_pos;
    fsg_evt_t         evt;

    fsg_src_sel #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_src (
        .clk        (clk),
        .rst        (rst),
        .ref_tick_i (ref_tick_i),
        .sync_i     (sync_i),
        .clk_sel    (cfg_clk_sel),
        .sync_sel   (cfg_sync_sel),
        .tick_o     (tick_sel),
        .edge_o     (sync_edge)
    );

    fsg_phase_ctr #(.TPF(TICKS_PER_FRAME), .FPS(FRAMES_PER_PPS)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_sel),
        .edge_i    (sync_edge),
        .rate_i    (sync_rate_e'(cfg_sync_rate)),
        .evt_o     (evt),
        .aligned_o (seg_aligned),
        .pos_o     (tick_pos)
    );

    fsg_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .edge_i    (sync_edge),
        .aligned_i (seg_aligned),
        .clr_i     (status_clr),
        .bad_o     (edge_bad),
        .flag_o    (misalign_o)
    );

    fsg_pulse_out u_out (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_sel),
        .evt_i        (evt),
        .frame_pps_i  (cfg_frame_pps),
        .mframe_pps_i (cfg_mframe_pps),
        .frame_o      (frame_pulse_o),
        .mframe_o     (mframe_pulse_o)
    );

endmodule

// File: rtl/frame_sync_gen_chk.sv
module frame_sync_gen_chk #(
    parameter int TPF = 1250,
    parameter int TW  = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_sel,
    input logic          sync_edge,
    input logic          edge_bad,
    input logic          status_clr,
    input logic          cfg_frame_pps,
    input logic          frame_pulse_o,
    input logic          mframe_pulse_o,
    input logic          misalign_o,
    input logic [TW-1:0] tick_pos
);
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_sel |=> ($stable(frame_pulse_o) && $stable(mframe_pulse_o))); // R10

    AST_ALIGN_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (sync_edge && tick_sel && !cfg_frame_pps) |=> frame_pulse_o); // R7

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        edge_bad |=> misalign_o); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (misalign_o && !status_clr) |=> misalign_o); // R9

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (status_clr && !edge_bad) |=> !misalign_o); // R9

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        tick_pos <= TW'(TPF - 1)); // R2

endmodule

bind frame_sync_gen frame_sync_gen_chk #(.TPF(TICKS_PER_FRAME), .TW(POS_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tick_sel       (tick_sel),
    .sync_edge      (sync_edge),
    .edge_bad       (edge_bad),
    .status_clr     (status_clr),
    .cfg_frame_pps  (cfg_frame_pps),
    .frame_pulse_o  (frame_pulse_o),
    .mframe_pulse_o (mframe_pulse_o),
    .misalign_o     (misalign_o),
    .tick_pos       (tick_pos)
);

// File: tb/frame_sync_gen_tb_top.sv
module frame_sync_gen_tb_top;
    localparam int NI  = 4;
    localparam int TPF = 4;
    localparam int FPS = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] ref_tick_i;
    logic [3:0] sync_i;
    logic [1:0] cfg_clk_sel, cfg_sync_sel, cfg_sync_rate;
    logic       cfg_frame_pps, cfg_mframe_pps, status_clr;
    logic       frame_pulse_o, mframe_pulse_o, misalign_o;

    always #5 clk = ~clk;

    frame_sync_gen #(.NUM_IN(NI), .TICKS_PER_FRAME(TPF), .FRAMES_PER_PPS(FPS)) dut_i (
        .clk(clk), .rst(rst), .ref_tick_i(ref_tick_i), .sync_i(sync_i),
        .cfg_clk_sel(cfg_clk_sel), .cfg_sync_sel(cfg_sync_sel),
        .cfg_sync_rate(cfg_sync_rate), .cfg_frame_pps(cfg_frame_pps),
        .cfg_mframe_pps(cfg_mframe_pps), .status_clr(status_clr),
        .frame_pulse_o(frame_pulse_o), .mframe_pulse_o(mframe_pulse_o),
        .misalign_o(misalign_o)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    typedef struct {
        logic  fr;
        logic  mf;
        logic  fl;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // bench reference model state (clock input 1, sync input 2)
    int   m_t, m_mf, m_sec, gcnt;
    bit   m_arm, m_flag, m_fr, m_mfp, m_prev;
    logic [3:0] sync_lvl;

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    function automatic bit model_aligned();
        bit ok;
        case (cfg_sync_rate)
            2'd0:    ok = (m_mf == 0) && (m_sec == 0);
            2'd1:    ok = (m_mf == 0);
            2'd2:    ok = (m_mf % 2 == 0);
            default: ok = 1'b1;
        endcase
        return (m_t == 0) && ok;
    endfunction

    task automatic model_step(bit tk, bit s, bit clr);
        bit edg, bad, fe, me, se;
        int et, em, es;
        edg    = s && !m_prev;
        m_prev = s;
        bad    = edg && m_arm && !model_aligned();
        if (edg) m_arm = 1'b1;
        if (bad)      m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        et = edg ? 0 : m_t;
        em = (edg && cfg_sync_rate <= 2'd1) ? 0 : m_mf;
        es = (edg && cfg_sync_rate == 2'd0) ? 0 : m_sec;
        if (tk) begin
            fe    = (et == 0);
            me    = fe && (em == 0);
            se    = fe && (es == 0);
            m_fr  = cfg_frame_pps  ? se : fe;
            m_mfp = cfg_mframe_pps ? se : me;
            if (et == TPF - 1) begin
                m_t   = 0;
                m_mf  = (em + 1) % 4;
                m_sec = (es == FPS - 1) ? 0 : es + 1;
            end else begin
                m_t = et + 1; m_mf = em; m_sec = es;
            end
        end else begin
            m_t = et; m_mf = em; m_sec = es;
        end
    endtask

    // driver: one cycle of stimulus, then push the expected outputs
    task automatic cyc(string tag, bit clr);
        logic [3:0] tk;
        exp_t e;
        @(negedge clk);
        tk[0] = 1'b1;                  // noise clock, not selected (R5)
        tk[1] = (gcnt % 2 == 1);       // selected reference
        tk[2] = (gcnt % 5 == 0);
        tk[3] = (gcnt % 3 == 0);
        ref_tick_i = tk;
        sync_i     = sync_lvl;
        status_clr = clr;
        gcnt++;
        @(posedge clk);
        #1;
        model_step(tk[1], sync_lvl[2], clr);
        e.fr = m_fr; e.mf = m_mfp; e.fl = m_flag; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare each cycle against the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(e.tag, "frame_pulse_o",  frame_pulse_o,  e.fr);
            check(e.tag, "mframe_pulse_o", mframe_pulse_o, e.mf);
            check(e.tag, "misalign_o",     misalign_o,     e.fl);
        end
    end

    // raise the selected sync line in a cycle chosen by alignment and tick parity
    task automatic edge_at(string tag, bit want_aligned, bit on_tick, bit clr);
        int guard = 0;
        while (((model_aligned() != want_aligned) || ((gcnt % 2 == 1) != on_tick))
               && guard < 600) begin
            cyc(tag, 1'b0);
            guard++;
        end
        sync_lvl[2] = 1'b1;
        cyc(tag, clr);
        #2;
        check(tag, "misalign_o after edge", misalign_o, m_flag);
        repeat (2) cyc(tag, 1'b0);
        sync_lvl[2] = 1'b0;
        repeat (3) cyc(tag, 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        ref_tick_i = '0; sync_i = '0; sync_lvl = '0;
        cfg_clk_sel = 2'd1; cfg_sync_sel = 2'd2; cfg_sync_rate = 2'd3;
        cfg_frame_pps = 1'b0; cfg_mframe_pps = 1'b0; status_clr = 1'b0;
        m_t = 0; m_mf = 0; m_sec = 0; gcnt = 0;
        m_arm = 0; m_flag = 0; m_fr = 0; m_mfp = 0; m_prev = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "frame_pulse_o reset",  frame_pulse_o,  1'b0);
        check("R1", "mframe_pulse_o reset", mframe_pulse_o, 1'b0);
        check("R1", "misalign_o reset",     misalign_o,     1'b0);
        rst = 1'b0;

        repeat (40) cyc("R1 R2 R3 free-run", 1'b0);
        cfg_frame_pps = 1'b1;
        repeat (70) cyc("R4 frame pps", 1'b0);
        cfg_frame_pps = 1'b0; cfg_mframe_pps = 1'b1;
        repeat (70) cyc("R4 multiframe pps", 1'b0);
        cfg_mframe_pps = 1'b0;

        // first edge is never judged
        edge_at("R11 first edge", 1'b0, 1'b0, 1'b0);
        #2; check("R11", "misalign_o", misalign_o, 1'b0);

        // activity on a sync input that is not selected
        sync_lvl[3] = 1'b1; repeat (4) cyc("R5 other sync", 1'b0);
        sync_lvl[3] = 1'b0; repeat (4) cyc("R5 other sync", 1'b0);
        #2; check("R5", "misalign_o", misalign_o, 1'b0);

        // 8 kHz rate: off-time edge, clear, on-time edge
        edge_at("R8 late 8k edge off tick", 1'b0, 1'b0, 1'b0);
        #2; check("R8", "misalign_o", misalign_o, 1'b1);
        cyc("R9 clear", 1'b1);
        #2; check("R9", "misalign_o", misalign_o, 1'b0);
        edge_at("R8 on-time 8k edge", 1'b1, 1'b1, 1'b0);
        edge_at("R7 edge on tick", 1'b0, 1'b1, 1'b0);
        edge_at("R9 edge with clear", 1'b0, 1'b0, 1'b1);
        #2; check("R9", "set wins over clear", misalign_o, 1'b1);
        cyc("R9 clear", 1'b1);
        repeat (20) cyc("R6 8k after", 1'b0);

        // 2 kHz and 4 kHz rates
        cfg_sync_rate = 2'd1;
        edge_at("R6 2k edge off time", 1'b0, 1'b1, 1'b0);
        repeat (40) cyc("R6 2k after", 1'b0);
        edge_at("R8 2k edge on time", 1'b1, 1'b0, 1'b1);
        cfg_sync_rate = 2'd2;
        edge_at("R6 4k edge off time", 1'b0, 1'b0, 1'b1);
        repeat (40) cyc("R6 4k after", 1'b0);

        // 1 PPS rate with both outputs in once-per-second mode
        cfg_sync_rate = 2'd0; cfg_frame_pps = 1'b1; cfg_mframe_pps = 1'b1;
        cyc("R9 clear", 1'b1);
        edge_at("R6 pps edge off time", 1'b0, 1'b1, 1'b0);
        repeat (140) cyc("R4 R6 pps after", 1'b0);
        edge_at("R8 pps edge on time", 1'b1, 1'b1, 1'b1);
        cfg_frame_pps = 1'b0; cfg_mframe_pps = 1'b0;
        repeat (40) cyc("R2 R3 after pps", 1'b0);

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule